// File: doc/BRIEF.md
# Unit Allocation Table Buffer Manager

This block hands out space in a shared buffer memory one fixed-size unit at a time, on demand. No payload has space set aside for it, so a fast stream can take many units while a slow one holds few. A table with one row per unit records whether the unit is in use, which payload owns it, what kind of data it holds, and which unit follows it. The memory datapath itself lives elsewhere. This block only decides unit addresses.

A writer asks for a unit on the allocation channel, giving a payload ID and a data type, and gets back a unit address in the same cycle. A reader drains a payload on the release channel. Each accepted release returns that payload's oldest unit and its data type, then puts the unit back in the pool. Units not in use sit on a first-in first-out free list. After reset the list holds units 0 to 63 in ascending order. A released unit joins the back of the list and an allocation takes the front.

Both channels use valid/ready. A transfer happens on a clock edge where valid and ready are both high. `alloc_ready` falls only when the free list is empty and no release is accepted in the same cycle. `rel_ready` is high only while the selected payload owns at least one unit. The unit outputs are valid in the cycle of the transfer. A requester may hold valid high while ready is low; nothing changes until the transfer takes place.

Top module: `bat_buffer_mgr`

## Requirements
- R1: After reset `free_count` is 64, `alloc_ready` is 1, `alloc_full` is 0, and `rel_ready` is 0 for every payload ID.
- R2: An accepted allocation with a non-empty free list returns the unit at the front of the free list. Right after reset these are 0, 1, 2 and so on. Every released unit that is not passed on joins the back of the list.
- R3: When the free list is empty and no release is accepted in that cycle, `alloc_ready` is 0 and `alloc_full` is 1. A pending allocation then changes neither the table nor `free_count`.
- R4: Releases for a payload return its units in the order they were allocated, each with the 2-bit data type given when it was allocated.
- R5: `rel_ready` is 0 while the selected payload owns no unit, and `rel_valid` then has no effect on `free_count` or on later allocations.
- R6: An allocation and a release accepted in the same cycle both complete. If the free list is empty, `alloc_unit` equals `rel_unit` and `free_count` stays 0.
- R7: `free_count` always equals 64 minus the number of units in use.
- R8: Payload IDs 0 to 3 each keep a separate arrival-ordered chain, so interleaved allocations for different IDs never mix their release order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocation request |
| alloc_ready | output | 1 | A unit can be granted this cycle |
| alloc_owner | input | 2 | Payload ID of the request |
| alloc_type | input | 2 | Data type stored with the unit |
| alloc_unit | output | 6 | Granted unit address |
| alloc_full | output | 1 | No unit available this cycle |
| rel_valid | input | 1 | Release request |
| rel_ready | output | 1 | The selected payload owns a unit |
| rel_owner | input | 2 | Payload ID to drain |
| rel_unit | output | 6 | Oldest unit of that payload |
| rel_type | output | 2 | Data type of that unit |
| free_count | output | 7 | Number of units not in use |

## Verification
Allocation and release can fall in the same cycle, and that case matters most when the free list is empty, because the released unit must pass straight to the allocation. The bench first fills all 64 units and checks that a lone allocation is refused. It then raises both requests together and requires the granted unit to equal the released one, with the free count held at 0. Random traffic then mixes the two channels at many fill levels. Every grant and every release is compared with a FIFO model of the free list and of each payload's chain.

// File: rtl/bat_pkg.sv
package bat_pkg;
  localparam int DEF_UNITS  = 64;
  localparam int DEF_OWNERS = 4;
  localparam int DEF_TYPES  = 4;
endpackage

// File: rtl/bat_table.sv
module bat_table #(
  parameter int UNITS = 64,
  parameter int OWN_W = 2,
  parameter int TYP_W = 2,
  localparam int UW = $clog2(UNITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_we,
  input  logic [UW-1:0]    set_idx,
  input  logic [OWN_W-1:0] set_own,
  input  logic [TYP_W-1:0] set_typ,
  input  logic             clr_we,
  input  logic [UW-1:0]    clr_idx,
  input  logic             lnk_a_we,
  input  logic [UW-1:0]    lnk_a_idx,
  input  logic [UW-1:0]    lnk_a_val,
  input  logic             lnk_b_we,
  input  logic [UW-1:0]    lnk_b_idx,
  input  logic [UW-1:0]    lnk_b_val,
  input  logic [UW-1:0]    q_idx,
  output logic [UW-1:0]    q_nxt,
  output logic [TYP_W-1:0] q_typ,
  output logic [OWN_W-1:0] q_own,
  input  logic [UW-1:0]    f_idx,
  output logic [UW-1:0]    f_nxt,
  output logic [UNITS-1:0] in_use
);
  logic [UNITS-1:0] vld;
  logic [OWN_W-1:0] own [UNITS];
  logic [TYP_W-1:0] typ [UNITS];
  logic [UW-1:0]    nxt [UNITS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
      for (int i = 0; i < UNITS; i++) begin
        own[i] <= '0;
        typ[i] <= '0;
        nxt[i] <= UW'((i + 1) % UNITS);
      end
    end else begin
      if (clr_we) vld[clr_idx] <= 1'b0;
      if (set_we) begin
        vld[set_idx] <= 1'b1;
        own[set_idx] <= set_own;
        typ[set_idx] <= set_typ;
      end
      if (lnk_a_we) nxt[lnk_a_idx] <= lnk_a_val;
      if (lnk_b_we) nxt[lnk_b_idx] <= lnk_b_val;
    end
  end

  assign q_nxt  = nxt[q_idx];
  assign q_typ  = typ[q_idx];
  assign q_own  = own[q_idx];
  assign f_nxt  = nxt[f_idx];
  assign in_use = vld;

  AST_LINKS_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
    (lnk_a_we && lnk_b_we) |-> (lnk_a_idx != lnk_b_idx)); // R6
  AST_SET_TARGET_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (set_we && !clr_we) |-> !vld[set_idx]); // R2
endmodule

// File: rtl/bat_freelist.sv
module bat_freelist #(
  parameter int UNITS = 64,
  localparam int UW = $clog2(UNITS),
  localparam int CW = $clog2(UNITS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pop,
  input  logic          push,
  input  logic [UW-1:0] push_unit,
  input  logic [UW-1:0] head_nxt,
  output logic [UW-1:0] head,
  output logic [CW-1:0] cnt,
  output logic          lnk_we,
  output logic [UW-1:0] lnk_idx
);
  logic [UW-1:0] tail;
  logic [CW-1:0] remain;

  always_comb begin
    remain  = cnt - CW'(pop);
    lnk_we  = push && (remain != '0);
    lnk_idx = tail;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head <= '0;
      tail <= UW'(UNITS - 1);
      cnt  <= CW'(UNITS);
    end else begin
      cnt <= cnt - CW'(pop) + CW'(push);
      if (pop)
        head <= (remain == '0) ? push_unit : head_nxt;
      else if (push && cnt == '0)
        head <= push_unit;
      if (push) tail <= push_unit;
    end
  end

  AST_POP_NEEDS_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt != '0)); // R3
  AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(UNITS)); // R7
endmodule

// File: rtl/bat_queues.sv
module bat_queues #(
  parameter int UNITS  = 64,
  parameter int OWNERS = 4,
  localparam int UW    = $clog2(UNITS),
  localparam int CW    = $clog2(UNITS + 1),
  localparam int OWN_W = $clog2(OWNERS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             deq,
  input  logic [OWN_W-1:0] deq_owner,
  input  logic             enq,
  input  logic [OWN_W-1:0] enq_owner,
  input  logic [UW-1:0]    enq_unit,
  input  logic [UW-1:0]    head_nxt,
  output logic [UW-1:0]    sel_head,
  output logic             sel_nonempty,
  output logic             lnk_we,
  output logic [UW-1:0]    lnk_idx
);
  logic [UW-1:0] hd_a [OWNERS];
  logic [UW-1:0] tl_a [OWNERS];
  logic [CW-1:0] ct_a [OWNERS];

  for (genvar g = 0; g < OWNERS; g++) begin : g_chain
    logic          d_hit, e_hit;
    logic [UW-1:0] hd, tl;
    logic [CW-1:0] ct, rem;
    assign d_hit = deq && (deq_owner == OWN_W'(g));
    assign e_hit = enq && (enq_owner == OWN_W'(g));
    assign rem   = ct - CW'(d_hit);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        hd <= '0;
        tl <= '0;
        ct <= '0;
      end else begin
        ct <= rem + CW'(e_hit);
        if (d_hit)
          hd <= (rem == '0) ? enq_unit : head_nxt;
        else if (e_hit && ct == '0)
          hd <= enq_unit;
        if (e_hit) tl <= enq_unit;
      end
    end
    assign hd_a[g] = hd;
    assign tl_a[g] = tl;
    assign ct_a[g] = ct;
  end

  logic          same_owner;
  logic [CW-1:0] enq_rem;

  always_comb begin
    same_owner   = deq && (deq_owner == enq_owner);
    enq_rem      = ct_a[enq_owner] - CW'(same_owner);
    lnk_we       = enq && (enq_rem != '0);
    lnk_idx      = tl_a[enq_owner];
    sel_head     = hd_a[deq_owner];
    sel_nonempty = (ct_a[deq_owner] != '0);
  end

  AST_DEQ_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    deq |-> (ct_a[deq_owner] != '0)); // R5
endmodule

// File: rtl/bat_buffer_mgr.sv
module bat_buffer_mgr
  import bat_pkg::*;
#(
  parameter int UNITS  = DEF_UNITS,
  parameter int OWNERS = DEF_OWNERS,
  parameter int TYPES  = DEF_TYPES,
  localparam int UW    = $clog2(UNITS),
  localparam int CW    = $clog2(UNITS + 1),
  localparam int OWN_W = $clog2(OWNERS),
  localparam int TYP_W = $clog2(TYPES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_valid,
  output logic             alloc_ready,
  input  logic [OWN_W-1:0] alloc_owner,
  input  logic [TYP_W-1:0] alloc_type,
  output logic [UW-1:0]    alloc_unit,
  output logic             alloc_full,
  input  logic             rel_valid,
  output logic             rel_ready,
  input  logic [OWN_W-1:0] rel_owner,
  output logic [UW-1:0]    rel_unit,
  output logic [TYP_W-1:0] rel_type,
  output logic [CW-1:0]    free_count
);
  logic             alloc_fire, rel_fire, fl_empty, pass_on;
  logic             fl_pop, fl_push;
  logic [UW-1:0]    fl_head, fl_head_nxt, q_head_nxt, q_head;
  logic             q_nonempty;
  logic             fl_lnk_we, q_lnk_we;
  logic [UW-1:0]    fl_lnk_idx, q_lnk_idx;
  logic [OWN_W-1:0] q_own;
  logic [UNITS-1:0] in_use;

  always_comb begin
    fl_empty    = (free_count == '0);
    rel_ready   = q_nonempty;
    rel_fire    = rel_valid && q_nonempty;
    alloc_ready = !fl_empty || rel_fire;
    alloc_full  = !alloc_ready;
    alloc_fire  = alloc_valid && alloc_ready;
    pass_on     = alloc_fire && fl_empty;
    fl_pop      = alloc_fire && !fl_empty;
    fl_push     = rel_fire && !pass_on;
    rel_unit    = q_head;
    alloc_unit  = fl_empty ? q_head : fl_head;
  end

  bat_freelist #(.UNITS(UNITS)) u_free (
    .clk(clk), .rst_n(rst_n),
    .pop(fl_pop), .push(fl_push), .push_unit(q_head),
    .head_nxt(fl_head_nxt), .head(fl_head), .cnt(free_count),
    .lnk_we(fl_lnk_we), .lnk_idx(fl_lnk_idx)
  );

  bat_queues #(.UNITS(UNITS), .OWNERS(OWNERS)) u_chain (
    .clk(clk), .rst_n(rst_n),
    .deq(rel_fire), .deq_owner(rel_owner),
    .enq(alloc_fire), .enq_owner(alloc_owner), .enq_unit(alloc_unit),
    .head_nxt(q_head_nxt), .sel_head(q_head), .sel_nonempty(q_nonempty),
    .lnk_we(q_lnk_we), .lnk_idx(q_lnk_idx)
  );

  bat_table #(.UNITS(UNITS), .OWN_W(OWN_W), .TYP_W(TYP_W)) u_tab (
    .clk(clk), .rst_n(rst_n),
    .set_we(alloc_fire), .set_idx(alloc_unit), .set_own(alloc_owner), .set_typ(alloc_type),
    .clr_we(rel_fire), .clr_idx(q_head),
    .lnk_a_we(q_lnk_we), .lnk_a_idx(q_lnk_idx), .lnk_a_val(alloc_unit),
    .lnk_b_we(fl_lnk_we), .lnk_b_idx(fl_lnk_idx), .lnk_b_val(q_head),
    .q_idx(q_head), .q_nxt(q_head_nxt), .q_typ(rel_type), .q_own(q_own),
    .f_idx(fl_head), .f_nxt(fl_head_nxt), .in_use(in_use)
  );

  AST_COUNT_MATCHES_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
    free_count == CW'(UNITS - $countones(in_use))); // R7
  AST_REFUSE_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && alloc_full) |=> $stable(in_use)); // R3
  AST_GRANT_UNUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_fire && !rel_fire) |-> !in_use[alloc_unit]); // R2
  AST_RELEASE_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
    rel_fire |-> (in_use[rel_unit] && q_own == rel_owner)); // R4
  AST_PASS_ON_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    pass_on |=> (in_use[$past(alloc_unit)] && free_count == '0)); // R6
endmodule

// File: tb/sim_bat_buffer_mgr.sv
module sim_bat_buffer_mgr;
  localparam int PERIOD = 10;
  localparam int N = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic alloc_valid = 1'b0, rel_valid = 1'b0;
  logic [1:0] alloc_owner = '0, alloc_type = '0, rel_owner = '0;
  logic alloc_ready, alloc_full, rel_ready;
  logic [5:0] alloc_unit, rel_unit;
  logic [1:0] rel_type;
  logic [6:0] free_count;

  int n_chk = 0, n_fail = 0;
  int fu [N]; int fh = 0, fc = 0;
  int ou [4][N]; int ot [4][N]; int oh [4]; int oc [4];

  always #(PERIOD/2) clk = ~clk;

  bat_buffer_mgr u0 (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_ready(alloc_ready), .alloc_owner(alloc_owner),
    .alloc_type(alloc_type), .alloc_unit(alloc_unit), .alloc_full(alloc_full),
    .rel_valid(rel_valid), .rel_ready(rel_ready), .rel_owner(rel_owner),
    .rel_unit(rel_unit), .rel_type(rel_type), .free_count(free_count)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int front_free();
    return fu[fh];
  endfunction

  task automatic cyc(input bit av, input int ao, input int at, input bit rv, input int ro);
    bit err, ear, rf, af, passed;
    int eu, et, xu;
    @(negedge clk);
    alloc_valid = av; alloc_owner = 2'(ao); alloc_type = 2'(at);
    rel_valid = rv; rel_owner = 2'(ro);
    #1;
    err = (oc[ro] != 0);
    ear = (fc != 0) || (rv && err);
    chk("R5 rel_ready", int'(rel_ready), int'(err));
    chk("R3 alloc_ready", int'(alloc_ready), int'(ear));
    chk("R3 alloc_full", int'(alloc_full), int'(!ear));
    rf = rv && err; af = av && ear;
    eu = 0; et = 0;
    if (rf) begin
      eu = ou[ro][oh[ro]]; et = ot[ro][oh[ro]];
      chk("R4 rel_unit order", int'(rel_unit), eu);
      chk("R4 rel_type", int'(rel_type), et);
    end
    passed = af && (fc == 0);
    if (af) begin
      xu = passed ? eu : front_free();
      chk(passed ? "R6 pass-on unit" : "R2 granted unit", int'(alloc_unit), xu);
    end
    if (rf) begin oh[ro] = (oh[ro] + 1) % N; oc[ro]--; end
    if (af) begin
      if (!passed) begin xu = fu[fh]; fh = (fh + 1) % N; fc--; end
      ou[ao][(oh[ao] + oc[ao]) % N] = xu;
      ot[ao][(oh[ao] + oc[ao]) % N] = at;
      oc[ao]++;
    end
    if (rf && !passed) begin fu[(fh + fc) % N] = eu; fc++; end
    @(posedge clk); #1;
    chk("R7 free_count", int'(free_count), fc);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(PERIOD * 190000);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < N; i++) fu[i] = i;
    fh = 0; fc = N;
    for (int o = 0; o < 4; o++) begin oh[o] = 0; oc[o] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; #1;
    // R1 reset state
    chk("R1 free_count", int'(free_count), N);
    chk("R1 alloc_ready", int'(alloc_ready), 1);
    chk("R1 alloc_full", int'(alloc_full), 0);
    for (int o = 0; o < 4; o++) begin
      rel_owner = 2'(o); #1;
      chk("R1 rel_ready", int'(rel_ready), 0);
    end
    // R5 release on empty payload has no effect
    cyc(0, 0, 0, 1, 2);
    cyc(1, 1, 3, 1, 2);
    // R2/R8 fill memory with interleaved payloads
    for (int i = 0; i < N - 1; i++) cyc(1, i % 4, (i * 3) % 4, 0, 0);
    // R3 refusal when full, held for two cycles
    cyc(1, 2, 1, 0, 0);
    cyc(1, 3, 2, 0, 0);
    // R6 same-cycle release and allocation on empty list
    cyc(1, 3, 2, 1, 1);
    cyc(1, 0, 1, 1, 0);
    // R4 drain part, then random mix
    for (int i = 0; i < 20; i++) cyc(0, 0, 0, 1, i % 4);
    for (int i = 0; i < 5000; i++) begin
      int lvl;
      lvl = (i / 500) % 2 == 0 ? 70 : 35;
      cyc(($urandom % 100) < lvl, $urandom % 4, $urandom % 4,
          ($urandom % 100) < (100 - lvl), $urandom % 4);
    end
    // drain everything, back to full pool (R7)
    for (int o = 0; o < 4; o++) while (oc[o] != 0) cyc(0, 0, 0, 1, o);
    chk("R7 final free_count", int'(free_count), N);
    summary();
    $finish;
  end
endmodule